// File: doc/BRIEF.md
# Outphasing PWM Carrier Generator

This block is a cycle-accurate digital model of an outphasing pulse-width modulated carrier source. A fast tick clock divides one carrier period into `TICKS` equal steps. Two branches each produce a two-level square wave that is high for exactly half the period. Each branch is rotated by its own phase code. The modulated carrier is the logical AND of the two branches. The width of each pulse follows the phase difference between the two codes, and the position of the pulse carries the carrier phase.

The phase codes arrive already computed by upstream logic. The block takes a new pair once per carrier period, at the period boundary, and holds it for exactly one period, so codes are updated at the carrier rate. The two unmodified half-duty branch waves are also brought out on their own pins, so they can be combined outside the block without short pulses.

An optional rounding mode models a driver that swallows narrow pulses. For a programmable minimum width `W` ticks, a pulse narrower than `W/2` is removed, and a pulse from `W/2` up to `W` is stretched to exactly `W`. A nominal setting is `W = TICKS/10`, which corresponds to roughly 40 ps at a 2.4 GHz carrier.

Top module: `orpwm_gen`

## Requirements
- R1: While `rst_n` is low, every output is 0. After release, the tick count restarts at 0, so `frame_o` is high in the first cycle after release. The first period uses codes 0 and direct mode.
- R2: In the output slot for tick k of a period, each branch output is 1 exactly when (k − code) mod `TICKS` < `TICKS/2`. Each branch is therefore high for exactly `TICKS/2` ticks of every period.
- R3: In direct mode (`round_en_i` sampled as 0), `pwm_o` equals `branch_a_o AND branch_b_o` in every tick.
- R4: In direct mode, the high time of `pwm_o` per period is `TICKS/2 − min(d, TICKS − d)`, where d = (code_b − code_a) mod `TICKS`. For example, d = 0 gives a half-period pulse and d = `TICKS/2` gives no pulse.
- R5: Code inputs are sampled only on the clock edge that ends a cycle in which `load_o` is 1. They apply to the whole following period. Input changes at any other time have no effect on the outputs.
- R6: `load_o` is 1 for one cycle in every `TICKS` cycles, in the cycle where the tick count is `TICKS−1`. Outputs lag the tick count by one register. `frame_o` marks the output slot of tick 0, and `load_o` falls in output slot `TICKS−2`.
- R7: In rounding mode, let L be the length of the AND pulse and s its first tick. If 2·L < W, no pulse is output. If 2·L ≥ W and L < W, the output is high for exactly W ticks starting at s, wrapping around the period. If L ≥ W, the output is unchanged.
- R8: `round_en_i` and `min_width_i` are sampled together with the codes at the period boundary. Changes at other times have no effect.
- R9: The branch outputs do not depend on the rounding mode or on the minimum width.
- R10: A code of `TICKS` or more is reduced by subtracting `TICKS` once before use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, `TICKS` cycles per carrier period |
| rst_n | input | 1 | Synchronous active-low reset |
| code_a_i | input | CW | Phase code of branch A, in ticks |
| code_b_i | input | CW | Phase code of branch B, in ticks |
| round_en_i | input | 1 | 1 selects minimum-pulse rounding for the next period |
| min_width_i | input | CW | Minimum pulse width W, in ticks |
| load_o | output | 1 | High in the cycle whose closing edge samples the inputs |
| frame_o | output | 1 | High in the output slot of tick 0 |
| branch_a_o | output | 1 | Half-duty square wave of branch A |
| branch_b_o | output | 1 | Half-duty square wave of branch B |
| pwm_o | output | 1 | Modulated carrier, AND of the branches, optionally rounded |

CW is $clog2(TICKS).

## Verification
The bench builds the block with `TICKS = 20`, which gives a 5-bit code. This makes codes 20 to 31 reachable, so the out-of-range reduction is exercised. Pulse lengths from 0 to 10 ticks are covered, including wrap-around pulses that straddle the period boundary. Minimum widths up to 10 are used, both odd and even, so each rounding branch (removed, stretched and kept) is hit at its exact thresholds. Random values are driven on every input in every non-sampling cycle, so any leak of a mid-period change into the outputs would show up.

// File: rtl/orpwm_pkg.sv
// Shared definitions for the outphasing PWM generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package orpwm_pkg;

    // Output shaping selected for one carrier period.
    typedef enum logic {
        MODE_DIRECT  = 1'b0,
        MODE_ROUNDED = 1'b1
    } pwm_mode_e;

endpackage

// File: rtl/orpwm_tick_ctr.sv
// Tick counter: divides the carrier period into TICKS steps.
// Assumes TICKS >= 4 and even. wrap_o is high during the last tick of a period.
module orpwm_tick_ctr #(
    parameter int unsigned TICKS = 40,
    parameter int unsigned CW    = $clog2(TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] tick_o,
    output logic          wrap_o
);

    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] tick_q;

    // Step the tick count and return to zero after the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (tick_q == LAST) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign tick_o = tick_q;
    assign wrap_o = (tick_q == LAST);

    // R6: the count returns to zero after the last tick.
    assert_tick_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (tick_o == '0));

    // R6: otherwise the count moves up by exactly one.
    assert_tick_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> (tick_o == $past(tick_o) + 1'b1));

    // R6: the boundary strobe never lasts two cycles.
    assert_load_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> !wrap_o);

endmodule

// File: rtl/orpwm_branch.sv
// One outphasing branch. It latches its phase code at the period boundary
// and produces a square wave that is high for half the period, starting at the code.
// Assumes TICKS is even. Codes of TICKS or more are reduced by TICKS once.
module orpwm_branch #(
    parameter int unsigned TICKS = 40,
    parameter int unsigned CW    = $clog2(TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] code_i,
    input  logic [CW-1:0] tick_i,
    output logic [CW-1:0] code_o,
    output logic          sq_o
);

    localparam int unsigned  WW    = CW + 1;
    localparam logic [WW-1:0] NW   = WW'(TICKS);
    localparam logic [WW-1:0] HALF = WW'(TICKS / 2);

    logic [CW-1:0] code_q;
    logic [WW-1:0] code_ext;
    logic [CW-1:0] code_red;
    logic [WW-1:0] tick_ext;
    logic [WW-1:0] cur_ext;
    logic [WW-1:0] offset;
    logic [WW-1:0] hi_cnt;

    // Reduce an out-of-range code into 0..TICKS-1.
    always_comb begin
        code_ext = {1'b0, code_i};
        if (code_ext >= NW) begin
            code_red = CW'(code_ext - NW);
        end else begin
            code_red = code_i;
        end
    end

    // Hold the code for one full period, taking a new one only at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (load_i) begin
            code_q <= code_red;
        end
    end

    // Position of the current tick relative to the code, modulo TICKS.
    always_comb begin
        tick_ext = {1'b0, tick_i};
        cur_ext  = {1'b0, code_q};
        if (tick_ext >= cur_ext) begin
            offset = tick_ext - cur_ext;
        end else begin
            offset = tick_ext + NW - cur_ext;
        end
    end

    assign sq_o   = (offset < HALF);
    assign code_o = code_q;

    // Count the high ticks of each period for the duty check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (load_i) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + WW'(sq_o);
        end
    end

    // R2: each period contains exactly TICKS/2 high ticks.
    assert_branch_duty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> ((hi_cnt + WW'(sq_o)) == HALF));

    // R5: the held code moves only at the period boundary.
    assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(code_q));

endmodule

// File: rtl/orpwm_rounder.sv
// Minimum-pulse rounding. From the two held codes it computes the start and
// length of the AND pulse, applies the swallow/stretch rule for width W, and
// regenerates the rounded pulse over the period. Mode and W are latched at the boundary.
// Assumes TICKS is even and the codes are already in 0..TICKS-1.
module orpwm_rounder #(
    parameter int unsigned TICKS = 40,
    parameter int unsigned CW    = $clog2(TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          en_i,
    input  logic [CW-1:0] width_i,
    input  logic [CW-1:0] tick_i,
    input  logic [CW-1:0] code_a_i,
    input  logic [CW-1:0] code_b_i,
    output logic          pulse_o,
    output logic          en_o
);

    localparam int unsigned   WW   = CW + 1;
    localparam logic [WW-1:0] NW   = WW'(TICKS);
    localparam logic [WW-1:0] HALF = WW'(TICKS / 2);

    logic          en_q;
    logic [CW-1:0] w_q;
    logic [WW-1:0] a_ext, b_ext, w_ext;
    logic [WW-1:0] diff;
    logic [WW-1:0] start;
    logic [WW-1:0] len;
    logic [WW-1:0] len_r;
    logic [WW:0]   len_dbl;
    logic [WW-1:0] tick_ext;
    logic [WW-1:0] offset;
    logic [WW-1:0] hi_cnt;
    logic [WW-1:0] hi_total;

    // Latch the mode and the minimum width for the next period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            w_q  <= '0;
        end else if (load_i) begin
            en_q <= en_i;
            w_q  <= width_i;
        end
    end

    // Start tick and length of the AND of the two half-duty waves.
    always_comb begin
        a_ext = {1'b0, code_a_i};
        b_ext = {1'b0, code_b_i};
        if (b_ext >= a_ext) begin
            diff = b_ext - a_ext;
        end else begin
            diff = b_ext + NW - a_ext;
        end
        if (diff <= HALF) begin
            start = b_ext;
            len   = HALF - diff;
        end else begin
            start = a_ext;
            len   = diff - HALF;
        end
    end

    // Apply the swallow/stretch rule to the pulse length.
    always_comb begin
        w_ext   = {1'b0, w_q};
        len_dbl = {len, 1'b0};
        if (len_dbl < {1'b0, w_ext}) begin
            len_r = '0;
        end else if (len < w_ext) begin
            len_r = w_ext;
        end else begin
            len_r = len;
        end
    end

    // Regenerate the rounded pulse from its start tick, wrapping over the period.
    always_comb begin
        tick_ext = {1'b0, tick_i};
        if (tick_ext >= start) begin
            offset = tick_ext - start;
        end else begin
            offset = tick_ext + NW - start;
        end
    end

    assign pulse_o = (offset < len_r);
    assign en_o    = en_q;

    // Count the rounded high ticks of each period for the width check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (load_i) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + WW'(pulse_o);
        end
    end

    assign hi_total = hi_cnt + WW'(pulse_o);

    // R7: in rounding mode, a pulse that survives is never narrower than W.
    assert_round_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && en_q && (hi_total != '0)) |-> (hi_total >= {1'b0, w_q}));

    // R8: mode and width move only at the period boundary.
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(en_q) && $stable(w_q)));

endmodule

// File: rtl/orpwm_gen.sv
// Outphasing PWM carrier generator (top). The tick counter sets the period
// boundary. Two branches make half-duty waves shifted by their codes. The carrier
// is their AND, or the rounded pulse when rounding mode is latched for the period.
// All outputs are registered, one cycle behind the tick count.
// Assumes TICKS is even and at least 4.
module orpwm_gen #(
    parameter int unsigned TICKS = 40,
    parameter int unsigned CW    = $clog2(TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] code_a_i,
    input  logic [CW-1:0] code_b_i,
    input  logic          round_en_i,
    input  logic [CW-1:0] min_width_i,
    output logic          load_o,
    output logic          frame_o,
    output logic          branch_a_o,
    output logic          branch_b_o,
    output logic          pwm_o
);

    import orpwm_pkg::*;

    localparam int unsigned NBR = 2;

    logic [CW-1:0] tick;
    logic          wrap;
    logic [CW-1:0] code_in [NBR];
    logic [CW-1:0] code_cur[NBR];
    logic          sq      [NBR];
    logic          rnd_pulse;
    logic          rnd_en;
    pwm_mode_e     mode_cur;
    pwm_mode_e     mode_q;

    orpwm_tick_ctr #(.TICKS(TICKS), .CW(CW)) ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick),
        .wrap_o (wrap)
    );

    assign code_in[0] = code_a_i;
    assign code_in[1] = code_b_i;

    for (genvar g = 0; g < NBR; g++) begin : g_branch
        orpwm_branch #(.TICKS(TICKS), .CW(CW)) br_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (wrap),
            .code_i (code_in[g]),
            .tick_i (tick),
            .code_o (code_cur[g]),
            .sq_o   (sq[g])
        );
    end

    orpwm_rounder #(.TICKS(TICKS), .CW(CW)) rnd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (wrap),
        .en_i     (round_en_i),
        .width_i  (min_width_i),
        .tick_i   (tick),
        .code_a_i (code_cur[0]),
        .code_b_i (code_cur[1]),
        .pulse_o  (rnd_pulse),
        .en_o     (rnd_en)
    );

    assign mode_cur = rnd_en ? MODE_ROUNDED : MODE_DIRECT;

    // Register the outputs of the current tick, using the shaping held for the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_o    <= 1'b0;
            branch_a_o <= 1'b0;
            branch_b_o <= 1'b0;
            pwm_o      <= 1'b0;
            mode_q     <= MODE_DIRECT;
        end else begin
            frame_o    <= (tick == '0);
            branch_a_o <= sq[0];
            branch_b_o <= sq[1];
            pwm_o      <= (mode_cur == MODE_ROUNDED) ? rnd_pulse : (sq[0] & sq[1]);
            mode_q     <= mode_cur;
        end
    end

    assign load_o = wrap;

    // R3: in direct mode the carrier is high only where both branches are high.
    assert_direct_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_o && (mode_q == MODE_DIRECT)) |-> (branch_a_o && branch_b_o));

    // R6: the tick-0 marker is a single-cycle pulse.
    assert_frame_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |=> !frame_o);

endmodule

// File: tb/orpwm_gen_tb_top.sv
// Self-checking bench for orpwm_gen. Directed corner periods come first, then random
// periods. Random values are driven on every input outside the sampling cycle.
module orpwm_gen_tb_top;

    localparam int TICKS = 20;
    localparam int CW    = $clog2(TICKS);
    localparam int NDIR  = 14;
    localparam int NPER  = 260;
    localparam int WDOG  = 100000;

    typedef struct {
        int a;
        int b;
        int en;
        int w;
    } cfg_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] code_a_i = '0;
    logic [CW-1:0] code_b_i = '0;
    logic          round_en_i = 1'b0;
    logic [CW-1:0] min_width_i = '0;
    logic          load_o, frame_o, branch_a_o, branch_b_o, pwm_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    orpwm_gen #(.TICKS(TICKS)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_a_i    (code_a_i),
        .code_b_i    (code_b_i),
        .round_en_i  (round_en_i),
        .min_width_i (min_width_i),
        .load_o      (load_o),
        .frame_o     (frame_o),
        .branch_a_o  (branch_a_o),
        .branch_b_o  (branch_b_o),
        .pwm_o       (pwm_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int red(input int c);
        return (c >= TICKS) ? c - TICKS : c;
    endfunction

    function automatic bit sq_ref(input int k, input int c);
        return ((k - red(c) + TICKS) % TICKS) < (TICKS / 2);
    endfunction

    function automatic cfg_t directed(input int p);
        cfg_t c;
        case (p)
            0:  c = '{3, 3, 0, 0};
            1:  c = '{0, 10, 0, 0};
            2:  c = '{5, 12, 0, 0};
            3:  c = '{15, 2, 0, 0};
            4:  c = '{2, 15, 0, 0};
            5:  c = '{25, 5, 0, 0};
            6:  c = '{0, 9, 1, 4};
            7:  c = '{0, 8, 1, 4};
            8:  c = '{0, 7, 1, 4};
            9:  c = '{0, 6, 1, 4};
            10: c = '{4, 12, 1, 5};
            11: c = '{18, 5, 1, 5};
            12: c = '{0, 3, 1, 0};
            default: c = '{0, 9, 0, 6};
        endcase
        return c;
    endfunction

    // Compare one captured period with the configuration that was loaded for it.
    task automatic eval_frame(input cfg_t c, input bit sa[TICKS], input bit sb[TICKS],
                              input bit sp[TICKS], input bit sl[TICKS], input bit sf[TICKS]);
        bit raw[TICKS];
        int len, start, len_r, cnt, bad_a, bad_b, bad_p, bad_m;
        bit ep;
        len = 0; start = 0; cnt = 0; bad_a = 0; bad_b = 0; bad_p = 0; bad_m = 0;
        for (int k = 0; k < TICKS; k++) begin
            raw[k] = sq_ref(k, c.a) && sq_ref(k, c.b);
            if (raw[k]) len++;
        end
        for (int k = 0; k < TICKS; k++)
            if (raw[k] && !raw[(k + TICKS - 1) % TICKS]) start = k;
        if (c.en == 0)         len_r = len;
        else if (2 * len < c.w) len_r = 0;
        else if (len < c.w)    len_r = c.w;
        else                   len_r = len;
        for (int k = 0; k < TICKS; k++) begin
            if (c.en != 0) ep = (len_r > 0) && (((k - start + TICKS) % TICKS) < len_r);
            else           ep = raw[k];
            if (sa[k] != sq_ref(k, c.a)) bad_a++;
            if (sb[k] != sq_ref(k, c.b)) bad_b++;
            if (sp[k] != ep) bad_p++;
            if (sp[k]) cnt++;
            if (sl[k] != (k == TICKS - 2) || sf[k] != (k == 0)) bad_m++;
        end
        // R2 / R9: branch waves follow their codes whatever the shaping mode.
        check(bad_a == 0, "R2/R9 branch A ticks wrong", bad_a, 0);
        check(bad_b == 0, "R2/R9 branch B ticks wrong", bad_b, 0);
        if (c.a >= TICKS || c.b >= TICKS)
            check(bad_a + bad_b == 0, "R10 out-of-range code not reduced", bad_a + bad_b, 0);
        if (c.en == 0) begin
            check(bad_p == 0, "R3 carrier differs from AND", bad_p, 0);
            check(cnt == len_r, "R4 carrier high time", cnt, len_r);
        end else begin
            check(bad_p == 0, "R7/R8 rounded carrier ticks", bad_p, 0);
            check(cnt == len_r, "R7 rounded high time", cnt, len_r);
        end
        check(bad_m == 0, "R6 load/frame marker position", bad_m, 0);
        // R5: all three waves match the boundary-sampled inputs despite mid-period noise.
        check(bad_a + bad_b + bad_p == 0, "R5 mid-period input leaked", bad_a + bad_b + bad_p, 0);
    endtask

    initial begin
        cfg_t cur, nxt, stim;
        bit sa[TICKS], sb[TICKS], sp[TICKS], sl[TICKS], sf[TICKS];
        int idx, frames, loaded, cyc, first_frame;
        bit active;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240);
        cur = '{0, 0, 0, 0};
        nxt = '{0, 0, 0, 0};
        idx = 0; frames = 0; loaded = 0; cyc = 0; first_frame = -1; active = 1'b0;

        // R1: outputs stay low while reset is held.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check({load_o, frame_o, branch_a_o, branch_b_o, pwm_o} == 5'b0,
                  "R1 outputs during reset", {load_o, frame_o, branch_a_o, branch_b_o, pwm_o}, 0);
        end
        rst_n = 1'b1;

        while (frames < NPER) begin
            @(negedge clk);
            cyc++;
            if (cyc > WDOG) begin
                check(1'b0, "watchdog expired", cyc, WDOG);
                break;
            end
            if (frame_o) begin
                if (first_frame < 0) begin
                    first_frame = cyc;
                    check(cyc == 1, "R1 first frame marker after release", cyc, 1);
                end
                if (active && idx != TICKS) check(1'b0, "R6 frame length", idx, TICKS);
                cur = nxt;
                active = 1'b1;
                idx = 0;
            end
            if (active && idx < TICKS) begin
                sa[idx] = branch_a_o; sb[idx] = branch_b_o; sp[idx] = pwm_o;
                sl[idx] = load_o;     sf[idx] = frame_o;
                idx++;
                if (idx == TICKS) begin
                    eval_frame(cur, sa, sb, sp, sl, sf);
                    frames++;
                end
            end
            if (load_o) begin
                if (loaded < NDIR) stim = directed(loaded);
                else stim = '{int'($urandom % 32), int'($urandom % 32),
                              int'($urandom % 2), int'($urandom % 11)};
                code_a_i = CW'(stim.a);
                code_b_i = CW'(stim.b);
                round_en_i = stim.en[0];
                min_width_i = CW'(stim.w);
                nxt = stim;
                loaded++;
            end else begin
                code_a_i = CW'($urandom);
                code_b_i = CW'($urandom);
                round_en_i = 1'($urandom);
                min_width_i = CW'($urandom);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule